// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block evaluates one arithmetic, logical, compare or shift step of a classic 8-bit accumulator machine and works out the new status byte for it. On each step the caller supplies an operation code, the accumulator, the X index register, an operand byte and the current status byte. The block returns a result byte, a code naming the register that should receive it, and the updated status byte. The caller owns the register file and decides whether to write the result back.

The core is combinational. It is split into three units: a logic and load unit, an adder-based arithmetic and compare unit, and a shift and step unit. A thin registered stage captures the selected result and status when the valid strobe is high, and raises done for exactly one cycle. The arithmetic is binary only. One unofficial operation is included: it masks the accumulator with X, subtracts the operand, and writes the difference to X.

Status layout: bit 7 N, bit 6 V, bit 5 spare, bit 4 B, bit 3 D, bit 2 I, bit 1 Z, bit 0 C.

Top module: `alu8_flags_unit`

## Requirements
- R1: Add (op 4) returns A + operand + C. C becomes bit 8 of the 9-bit sum. V is set when A and the operand share a sign and the result sign differs from A. Z and N follow the result.
- R2: Subtract (op 5) returns A − operand − (1 − C). C is set when no borrow occurs. V is set when A differs in sign from both the operand and the result. Z and N follow the result.
- R3: Compare with A (op 6) and compare with X (op 7) form the register minus the operand. The result port carries the low byte of the difference. Z and N come from that byte, C is set when the register is at least the operand, and V is untouched.
- R4: Bit test (op 8) returns A AND operand. Z is set when that value is zero, N copies operand bit 7, V copies operand bit 6, and C is untouched.
- R5: Shift left (op 9) moves operand bit 7 into C and fills bit 0 with zero. Shift right (op 10) moves operand bit 0 into C and fills bit 7 with zero, so N always ends clear. Z and N follow the result.
- R6: Rotate left (op 11) and rotate right (op 12) put the old C into the vacated bit and the bit shifted out into C. Z and N follow the result.
- R7: Masked subtract (op 15) returns (A AND X) − operand. C, Z and N are set exactly as for a compare, and V is untouched.
- R8: Load (op 0), AND (op 1), OR (op 2), XOR (op 3), increment (op 13, operand + 1) and decrement (op 14, operand − 1, modulo 256) change only Z (result zero) and N (result bit 7).
- R9: Status bits 5 to 2 always pass through unchanged. Any of N, V, Z or C that an operation does not name also passes through unchanged.
- R10: When valid is high at a rising edge, result, dest and status are registered at that edge, and done is high for the following cycle only. Done is low after a cycle with valid low.
- R11: While valid is low, result, dest and status hold their values, whatever the other inputs do.
- R12: While reset is asserted, result, dest, status and done are all zero.
- R13: The dest code is 1 for the accumulator (ops 0–5), 0 for no write (ops 6–8), 3 for the operand location (ops 9–14) and 2 for X (op 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid | input | 1 | Capture strobe for the current operation |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator value |
| xreg | input | 8 | X register value |
| operand | input | 8 | Operand byte |
| status_in | input | 8 | Current status byte |
| done | output | 1 | One-cycle pulse after a captured operation |
| result | output | 8 | Registered result byte |
| dest | output | 2 | Registered destination code |
| status_out | output | 8 | Registered new status byte |

## Verification
Every result, dest code and status byte is due at the first rising edge after valid is sampled high, and done is high during the cycle that follows that edge. The bench drives a new operation at each falling edge and checks the previous one at the next falling edge, one clock later. The sweep covers every operand and both carry values against sixteen accumulator values, for each of the sixteen operations, so the registered values are always compared exactly one edge after their inputs. The hold and reset checks wait whole cycles with valid low and compare the outputs against the last captured values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,  OP_AND  = 4'd1,  OP_OR   = 4'd2,  OP_XOR  = 4'd3,
    OP_ADC  = 4'd4,  OP_SBC  = 4'd5,  OP_CMPA = 4'd6,  OP_CMPX = 4'd7,
    OP_BIT  = 4'd8,  OP_ASL  = 4'd9,  OP_LSR  = 4'd10, OP_ROL  = 4'd11,
    OP_ROR  = 4'd12, OP_INC  = 4'd13, OP_DEC  = 4'd14, OP_AXS  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_ACC = 2'd1, DST_XR = 2'd2, DST_MEM = 2'd3
  } dst_e;

  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_V = 6;
  localparam int ST_N = 7;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flag_t;

  typedef struct packed {
    dst_e dst;
    logic upd_c;
    logic upd_v;
    logic upd_zn;
  } ctl_t;

  function automatic ctl_t decode_op(alu_op_e op);
    ctl_t k;
    k = '{dst: DST_ACC, upd_c: 1'b0, upd_v: 1'b0, upd_zn: 1'b1};
    case (op)
      OP_ADC, OP_SBC:   begin k.upd_c = 1'b1; k.upd_v = 1'b1; end
      OP_CMPA, OP_CMPX: begin k.dst = DST_NONE; k.upd_c = 1'b1; end
      OP_BIT:           begin k.dst = DST_NONE; k.upd_v = 1'b1; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR:
                        begin k.dst = DST_MEM; k.upd_c = 1'b1; end
      OP_INC, OP_DEC:   k.dst = DST_MEM;
      OP_AXS:           begin k.dst = DST_XR; k.upd_c = 1'b1; end
      default:          ;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output flag_t        flg
);
  localparam int MSB = W - 1;

  always_comb begin
    case (op)
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      OP_BIT:  res = acc & opnd;
      default: res = opnd;
    endcase
    flg.z = ~|res;
    flg.c = 1'b0;
    if (op == OP_BIT) begin
      // bit test: sign and overflow come straight from the operand
      flg.n = opnd[MSB];
      flg.v = opnd[MSB-1];
    end else begin
      flg.n = res[MSB];
      flg.v = 1'b0;
    end
  end

endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] xr,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] res,
  output flag_t        flg
);
  localparam int MSB = W - 1;

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         carry_in;
  logic [W:0]   sum;

  // One adder serves all: subtraction is lhs + ~rhs + carry_in.
  always_comb begin
    case (op)
      OP_CMPX: lhs = xr;
      OP_AXS:  lhs = acc & xr;
      default: lhs = acc;
    endcase
    rhs      = (op == OP_ADC) ? opnd : ~opnd;
    carry_in = (op == OP_ADC || op == OP_SBC) ? cin : 1'b1;
    sum      = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, carry_in};
    res      = sum[MSB:0];
    flg.c    = sum[W];
    flg.z    = ~|res;
    flg.n    = res[MSB];
    flg.v    = (lhs[MSB] == rhs[MSB]) && (res[MSB] != lhs[MSB]);
  end

endmodule

// File: rtl/alu8_shift_unit.sv
module alu8_shift_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] res,
  output flag_t        flg
);
  localparam int MSB = W - 1;

  always_comb begin
    flg.c = 1'b0;
    case (op)
      OP_ASL:  begin res = {opnd[MSB-1:0], 1'b0}; flg.c = opnd[MSB]; end
      OP_LSR:  begin res = {1'b0, opnd[MSB:1]};   flg.c = opnd[0];   end
      OP_ROL:  begin res = {opnd[MSB-1:0], cin};  flg.c = opnd[MSB]; end
      OP_ROR:  begin res = {cin, opnd[MSB:1]};    flg.c = opnd[0];   end
      OP_DEC:  res = opnd - {{(W-1){1'b0}}, 1'b1};
      default: res = opnd + {{(W-1){1'b0}}, 1'b1};
    endcase
    flg.z = ~|res;
    flg.n = res[MSB];
    flg.v = 1'b0;
  end

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] xreg,
  input  logic [W-1:0] operand,
  input  logic [7:0]   status_in,
  output logic         done,
  output logic [W-1:0] result,
  output logic [1:0]   dest,
  output logic [7:0]   status_out
);
  localparam int SYNC_STAGES = 2;

  alu_op_e      op_e;
  ctl_t         ctl;
  logic [W-1:0] res_lg, res_ar, res_sh, res_sel;
  flag_t        flg_lg, flg_ar, flg_sh, flg_sel;
  logic [7:0]   st_next;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  logic         done_q, done_d;
  logic [W-1:0] result_q, result_d;
  logic [1:0]   dest_q, dest_d;
  logic [7:0]   status_q, status_d;

  assign op_e = alu_op_e'(op);
  assign ctl  = decode_op(op_e);

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  alu8_logic_unit #(.W(W)) u_logic (
    .op(op_e), .acc(acc), .opnd(operand), .res(res_lg), .flg(flg_lg)
  );

  alu8_arith_unit #(.W(W)) u_arith (
    .op(op_e), .acc(acc), .xr(xreg), .opnd(operand), .cin(status_in[ST_C]),
    .res(res_ar), .flg(flg_ar)
  );

  alu8_shift_unit #(.W(W)) u_shift (
    .op(op_e), .opnd(operand), .cin(status_in[ST_C]), .res(res_sh), .flg(flg_sh)
  );

  always_comb begin
    case (op_e)
      OP_ADC, OP_SBC, OP_CMPA, OP_CMPX, OP_AXS:
        begin res_sel = res_ar; flg_sel = flg_ar; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_INC, OP_DEC:
        begin res_sel = res_sh; flg_sel = flg_sh; end
      default:
        begin res_sel = res_lg; flg_sel = flg_lg; end
    endcase
    st_next = status_in;
    if (ctl.upd_c)  st_next[ST_C] = flg_sel.c;
    if (ctl.upd_v)  st_next[ST_V] = flg_sel.v;
    if (ctl.upd_zn) begin
      st_next[ST_Z] = flg_sel.z;
      st_next[ST_N] = flg_sel.n;
    end
  end

  // next-state for the capture stage
  always_comb begin
    done_d   = valid;
    result_d = result_q;
    dest_d   = dest_q;
    status_d = status_q;
    if (valid) begin
      result_d = res_sel;
      dest_d   = ctl.dst;
      status_d = st_next;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
      dest_q   <= '0;
      status_q <= '0;
    end else begin
      done_q   <= done_d;
      result_q <= result_d;
      dest_q   <= dest_d;
      status_q <= status_d;
    end
  end

  assign done       = done_q;
  assign result     = result_q;
  assign dest       = dest_q;
  assign status_out = status_q;

  a_r10_done_after_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid |=> done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid |=> !done);
  a_r11_hold_outputs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid |=> ($stable(result) && $stable(status_out) && $stable(dest)));
  a_r9_spare_bits_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid |=> (status_out[5:2] == $past(status_in[5:2])));
  a_r5_lsr_n_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_LSR) |=> !status_out[ST_N]);
  a_r4_bit_copies_nv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_BIT) |=> (status_out[7:6] == $past(operand[W-1:W-2])));
  a_r3_compare_no_dest: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && (op == OP_CMPA || op == OP_CMPX)) |=> (dest == DST_NONE));
  a_r8_load_keeps_cv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && op == OP_LOAD) |=> (status_out[ST_C] == $past(status_in[ST_C])
                                  && status_out[ST_V] == $past(status_in[ST_V])));

endmodule

// File: tb/test_alu8_flags_unit.sv
`timescale 1ns/1ps
module test_alu8_flags_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [3:0] op;
  logic [7:0] acc, xreg, operand, status_in;
  logic       done;
  logic [7:0] result;
  logic [1:0] dest;
  logic [7:0] status_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alu8_flags_unit i_alu8_flags_unit (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .acc(acc), .xreg(xreg),
    .operand(operand), .status_in(status_in), .done(done), .result(result),
    .dest(dest), .status_out(status_out)
  );

  function automatic int put_bit(int st, int pos, int v);
    return (st & ~(1 << pos)) | ((v != 0 ? 1 : 0) << pos);
  endfunction

  function automatic string req_of(int o);
    case (o)
      4: return "R1/R13";
      5: return "R2/R13";
      6, 7: return "R3/R13";
      8: return "R4/R13";
      9, 10: return "R5/R13";
      11, 12: return "R6/R13";
      15: return "R7/R13";
      default: return "R8/R13";
    endcase
  endfunction

  // independent arithmetic model of each operation
  function automatic void model(input int o, input int a, input int x, input int b,
                                input int st_in, output int res, output int dst,
                                output int st);
    int c, s, upd_zn;
    c = st_in & 1;
    st = st_in;
    upd_zn = 1;
    case (o)
      0: begin res = b;     dst = 1; end
      1: begin res = a & b; dst = 1; end
      2: begin res = a | b; dst = 1; end
      3: begin res = a ^ b; dst = 1; end
      4: begin
        s = a + b + c; res = s % 256; dst = 1;
        st = put_bit(st, 0, s > 255);
        st = put_bit(st, 6, ((a ^ res) & (b ^ res) & 128) != 0);
      end
      5: begin
        s = a - b - (1 - c); res = (s + 512) % 256; dst = 1;
        st = put_bit(st, 0, s >= 0);
        st = put_bit(st, 6, ((a ^ b) & (a ^ res) & 128) != 0);
      end
      6: begin res = (a - b + 256) % 256; dst = 0; st = put_bit(st, 0, a >= b); end
      7: begin res = (x - b + 256) % 256; dst = 0; st = put_bit(st, 0, x >= b); end
      8: begin
        res = a & b; dst = 0; upd_zn = 0;
        st = put_bit(st, 1, res == 0);
        st = put_bit(st, 7, b >= 128);
        st = put_bit(st, 6, (b / 64) % 2);
      end
      9:  begin res = (b * 2) % 256;         dst = 3; st = put_bit(st, 0, b >= 128); end
      10: begin res = b / 2;                 dst = 3; st = put_bit(st, 0, b % 2); end
      11: begin res = (b * 2 + c) % 256;     dst = 3; st = put_bit(st, 0, b >= 128); end
      12: begin res = b / 2 + c * 128;       dst = 3; st = put_bit(st, 0, b % 2); end
      13: begin res = (b + 1) % 256;         dst = 3; end
      14: begin res = (b + 255) % 256;       dst = 3; end
      default: begin
        res = ((a & x) - b + 256) % 256; dst = 2;
        st = put_bit(st, 0, (a & x) >= b);
      end
    endcase
    if (upd_zn != 0) begin
      st = put_bit(st, 1, res == 0);
      st = put_bit(st, 7, res >= 128);
    end
  endfunction

  task automatic drive(int o, int a, int x, int b, int st);
    valid = 1'b1; op = 4'(o); acc = 8'(a); xreg = 8'(x);
    operand = 8'(b); status_in = 8'(st);
  endtask

  initial begin
    #(8 * 180000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int er, ed, es, last_r, last_d, last_s;
    rst_n = 1'b0; valid = 1'b0; op = '0; acc = '0; xreg = '0;
    operand = '0; status_in = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== 8'h00 || dest !== 2'd0 || status_out !== 8'h00) begin
      failures++;
      $display("FAIL R12 reset: actual done=%b res=%h dest=%0d st=%h expected all zero",
               done, result, dest, status_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int b = 0; b < 256; b++) begin
          for (int c = 0; c < 2; c++) begin
            int a, x, st;
            a  = (i == 14) ? 127 : (i == 15) ? 128 : i * 17;
            x  = (a ^ (b * 2) ^ 150) & 255;
            st = ((a ^ b ^ 165) & 254) | c;
            drive(o, a, x, b, st);
            model(o, a, x, b, st, er, ed, es);
            @(negedge clk);
            checks++;
            // R9 and R10 are covered here too: pass-through bits and done pulse
            if (result !== 8'(er) || dest !== 2'(ed) || status_out !== 8'(es) || done !== 1'b1) begin
              failures++;
              $display("FAIL %s/R9/R10 op=%0d a=%h x=%h b=%h st=%h: actual res=%h dest=%0d st=%h done=%b expected res=%h dest=%0d st=%h done=1",
                       req_of(o), o, a, x, b, st, result, dest, status_out, done,
                       8'(er), ed, 8'(es));
            end
          end
        end
      end
    end

    // R11: hold while valid is low, R10: done falls
    last_r = result; last_d = dest; last_s = status_out;
    valid = 1'b0; op = 4'd4; acc = 8'h3C; xreg = 8'hC3; operand = 8'h55; status_in = 8'hFF;
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      failures++;
      $display("FAIL R10 done after idle: actual %b expected 0", done);
    end
    operand = 8'hAA; op = 4'd9;
    @(negedge clk);
    checks++;
    if (result !== 8'(last_r) || dest !== 2'(last_d) || status_out !== 8'(last_s)) begin
      failures++;
      $display("FAIL R11 hold: actual res=%h dest=%0d st=%h expected res=%h dest=%0d st=%h",
               result, dest, status_out, 8'(last_r), last_d, 8'(last_s));
    end

    // R12: reset mid-run clears everything
    drive(2, 255, 0, 255, 255);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    #1;
    checks++;
    if (done !== 1'b0 || result !== 8'h00 || dest !== 2'd0 || status_out !== 8'h00) begin
      failures++;
      $display("FAIL R12 reset mid-run: actual done=%b res=%h dest=%0d st=%h expected all zero",
               done, result, dest, status_out);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule